// File: doc/BRIEF.md
# Fixed-Point Systolic Matrix Multiplier

This block multiplies two 4x4 signed fixed-point matrices, Y = A*B, on a grid of multiply-accumulate cells. Matrix B is written first, one row per cycle, and then stays held inside the grid as the stationary operand. Matrix A streams in as the moving operand, one row per cycle across four parallel lanes. Each cell multiplies, rescales the full product by a parameterised number of fraction bits, and adds the result to the partial sum coming from the cell above it. Partial sums move down the columns and A values move across the rows.

The wavefront through the grid is diagonal, but the caller never sees it. A delay line on each input lane skews the rows on the way in, and a delay line on each column aligns the results on the way out. Every output row therefore leaves on all four lanes in the same cycle, with one valid strobe.

A small controller sequences the work through four named states. In **IDLE**, `b_we` leads to **LOAD_B**, and `start` without `b_we` leads to **RUN**. **LOAD_B** returns to IDLE after the fourth row write. **RUN** accepts four A rows and then moves to **DRAIN**. **DRAIN** waits until the pipeline is empty and then returns to **IDLE**.

Top module: `fxsa_matmul`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears all state. After reset, `y_valid` is 0, `y_row` is all zero and the controller is idle.
- R2: A `b_we` seen in IDLE starts a load that writes B row 0. Each later cycle with `b_we` high writes the next row, up to row 3. Lane j of `b_row` (bits j*16+15..j*16) is B[r][j].
- R3: A `start` seen in IDLE with `b_we` low takes `a_row` as A row 0. The next three cycles take rows 1, 2 and 3 unconditionally. Lane k of `a_row` is A[i][k].
- R4: Lane j of output row i is the low 16 bits of the sum over k of (A[i][k]*B[k][j]). Each product is computed as a 32-bit signed value and arithmetically shifted right by FRAC_BIT (default 10). The sum is formed at full width before truncation.
- R5: Output row i is presented in the cycle after the 8th rising edge, counting the edge that accepted A row i as the first. `y_valid` is high for exactly 4 consecutive cycles per burst, and the rows come out in order 0 to 3.
- R6: `start` has no effect in LOAD_B, RUN or DRAIN. A burst produces only its own 4 valid rows.
- R7: `b_we` has no effect in RUN or DRAIN. B keeps its contents across bursts until a new load.
- R8: When `b_we` and `start` are both high in IDLE, the load wins and no burst starts.
- R9: The product shift rounds toward minus infinity. A product of raw value -1 contributes -1 LSB, and a product of raw value +1 contributes 0.
- R10: A reset in the middle of a burst cancels it. No valid row follows, and B is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| b_we | input | 1 | B row write request |
| b_row | input | 64 | B row, four 16-bit lanes |
| start | input | 1 | Begins an A burst with row 0 on `a_row` |
| a_row | input | 64 | A row, four 16-bit lanes |
| y_row | output | 64 | Result row, four 16-bit lanes |
| y_valid | output | 1 | `y_row` holds a result row |

## Verification
The hardest situation to reach is a request that arrives while the pipeline is still full. This covers a stray `start` or `b_we` during RUN or DRAIN, a simultaneous `start` and `b_we` in IDLE, and a reset with rows still in flight. The stimulus places each of these at a chosen cycle offset inside a burst. It then checks that exactly four rows come out, computed with the old B. A following burst with no reload confirms that B survived, or that the reset cleared it. Corner values such as full-scale operands and one-LSB products exercise truncation and the rounding of the shift.

// File: rtl/fxsa_pkg.sv
package fxsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOADB = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } fxsa_state_e;

endpackage

// File: rtl/fxsa_delay.sv
module fxsa_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stage [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
                end
            end
            assign q = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/fxsa_pe.sv
module fxsa_pe #(
    parameter int DW       = 16,
    parameter int ACC_W    = 34,
    parameter int FRAC_BIT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    a_in,
    input  logic [DW-1:0]    b_in,
    input  logic [ACC_W-1:0] ps_in,
    output logic [DW-1:0]    a_out,
    output logic [ACC_W-1:0] ps_out
);

    localparam int PW  = 2 * DW;
    localparam int EXT = ACC_W - PW;

    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    prod_sh;
    logic        [ACC_W-1:0] term;

    always_comb begin
        prod    = $signed(a_in) * $signed(b_in);
        prod_sh = prod >>> FRAC_BIT;
        term    = {{EXT{prod_sh[PW-1]}}, prod_sh};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_out  <= '0;
            ps_out <= '0;
        end else begin
            a_out  <= a_in;
            ps_out <= ps_in + term;
        end
    end

endmodule

// File: rtl/fxsa_ctrl.sv
module fxsa_ctrl
    import fxsa_pkg::*;
#(
    parameter int N   = 4,
    parameter int LAT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 b_we,
    output logic                 accept,
    output logic                 b_wr_en,
    output logic [$clog2(N)-1:0] b_wr_row
);

    localparam int CW  = $clog2(N);
    localparam int DCW = $clog2(LAT);
    localparam logic [CW-1:0]  LAST  = CW'(N - 1);
    localparam logic [DCW-1:0] DLAST = DCW'(LAT - 1);

    fxsa_state_e    state, nxt;
    logic [CW-1:0]  cnt, cnt_nxt;
    logic [DCW-1:0] dcnt, dcnt_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            dcnt  <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            dcnt  <= dcnt_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        dcnt_nxt = dcnt;
        unique case (state)
            ST_IDLE: begin
                if (b_we) begin
                    nxt     = ST_LOADB;
                    cnt_nxt = CW'(1);
                end else if (start) begin
                    nxt     = ST_RUN;
                    cnt_nxt = CW'(1);
                end
            end
            ST_LOADB: begin
                if (b_we) begin
                    if (cnt == LAST) begin
                        nxt     = ST_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CW'(1);
                    end
                end
            end
            ST_RUN: begin
                if (cnt == LAST) begin
                    nxt      = ST_DRAIN;
                    cnt_nxt  = '0;
                    dcnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_DRAIN: begin
                if (dcnt == DLAST) begin
                    nxt      = ST_IDLE;
                    dcnt_nxt = '0;
                end else begin
                    dcnt_nxt = dcnt + DCW'(1);
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = ((state == ST_IDLE) && start && !b_we) || (state == ST_RUN);
        b_wr_en  = ((state == ST_IDLE) || (state == ST_LOADB)) && b_we;
        b_wr_row = (state == ST_IDLE) ? '0 : cnt;
    end

    // R2: a load only finishes after the last row index has been written
    p_load_rows_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_LOADB && state == ST_IDLE) |-> ($past(cnt) == LAST && $past(b_we)));

    // R6: a running burst can never fall straight back to idle
    p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> (state == ST_RUN || state == ST_DRAIN));

    // R8: a write request in idle always opens a load
    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && b_we) |=> (state == ST_LOADB));

endmodule

// File: rtl/fxsa_matmul.sv
module fxsa_matmul #(
    parameter int N        = 4,
    parameter int DW       = 16,
    parameter int FRAC_BIT = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            b_we,
    input  logic [N*DW-1:0] b_row,
    input  logic            start,
    input  logic [N*DW-1:0] a_row,
    output logic [N*DW-1:0] y_row,
    output logic            y_valid
);

    localparam int ACC_W = 2 * DW + $clog2(N);
    localparam int LAT   = 2 * N;
    localparam int CW    = $clog2(N);
    localparam int RLW   = $clog2(N + 1) + 1;

    logic          accept;
    logic          b_wr_en;
    logic [CW-1:0] b_wr_row;

    fxsa_ctrl #(.N(N), .LAT(LAT)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .b_we     (b_we),
        .accept   (accept),
        .b_wr_en  (b_wr_en),
        .b_wr_row (b_wr_row)
    );

    // stationary operand store
    logic [N-1:0][N-1:0][DW-1:0] b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (b_wr_en) begin
            for (int c = 0; c < N; c++) b_q[b_wr_row][c] <= b_row[c*DW +: DW];
        end
    end

    logic [DW-1:0]    a_sk [N];
    logic [DW-1:0]    a_h  [N][N+1];
    logic [ACC_W-1:0] ps_v [N+1][N];
    logic [ACC_W-1:0] dsk  [N];

    genvar r, c;
    generate
        for (r = 0; r < N; r++) begin : g_skew
            fxsa_delay #(.W(DW), .DEPTH(r)) skew_i (
                .clk (clk),
                .rst (rst),
                .d   (accept ? a_row[r*DW +: DW] : '0),
                .q   (a_sk[r])
            );
            assign a_h[r][0] = a_sk[r];
        end

        for (c = 0; c < N; c++) begin : g_top
            assign ps_v[0][c] = '0;
        end

        for (r = 0; r < N; r++) begin : g_row
            for (c = 0; c < N; c++) begin : g_col
                fxsa_pe #(.DW(DW), .ACC_W(ACC_W), .FRAC_BIT(FRAC_BIT)) pe_i (
                    .clk    (clk),
                    .rst    (rst),
                    .a_in   (a_h[r][c]),
                    .b_in   (b_q[r][c]),
                    .ps_in  (ps_v[r][c]),
                    .a_out  (a_h[r][c+1]),
                    .ps_out (ps_v[r+1][c])
                );
            end
        end

        for (c = 0; c < N; c++) begin : g_deskew
            fxsa_delay #(.W(ACC_W), .DEPTH(N - 1 - c)) dsk_i (
                .clk (clk),
                .rst (rst),
                .d   (ps_v[N][c]),
                .q   (dsk[c])
            );
        end
    endgenerate

    logic [LAT-1:0] vpipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
            y_row <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], accept};
            for (int k = 0; k < N; k++) y_row[k*DW +: DW] <= dsk[k][DW-1:0];
        end
    end

    assign y_valid = vpipe[LAT-1];

    // checker state: length of the current valid run
    logic [RLW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (y_valid) run_len <= run_len + RLW'(1);
        else              run_len <= '0;
    end

    // R5: every run of valid rows is exactly N long
    p_run_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(y_valid) |-> (run_len == RLW'(N)));

    // R7: the stationary operand only changes on a granted write
    p_b_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!b_wr_en) |=> $stable(b_q));

    // R7: writes are only granted while no results are pending
    p_load_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        b_wr_en |-> !y_valid);

endmodule

// File: tb/fxsa_matmul_tb_top.sv
`timescale 1ns/1ps
module fxsa_matmul_tb_top;

    localparam int N  = 4;
    localparam int DW = 16;
    localparam int FB = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            b_we = 1'b0;
    logic [N*DW-1:0] b_row = '0;
    logic            start = 1'b0;
    logic [N*DW-1:0] a_row = '0;
    logic [N*DW-1:0] y_row;
    logic            y_valid;

    always #4 clk = ~clk;

    fxsa_matmul #(.N(N), .DW(DW), .FRAC_BIT(FB)) dut_i (
        .clk (clk), .rst (rst), .b_we (b_we), .b_row (b_row),
        .start (start), .a_row (a_row), .y_row (y_row), .y_valid (y_valid)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    logic [15:0] ma [16];
    logic [15:0] mb [16];
    logic [15:0] my [16];

    // stimulus table: {a_base, a_step, b_base, b_step}
    localparam logic [63:0] CASES [5] = '{
        64'h0400_0100_0400_0080,
        64'hF800_0123_0C00_FF37,
        64'h1234_0777_FE00_0041,
        64'h8001_1111_7FFF_F00F,
        64'h0001_0003_0200_0400
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    function automatic logic [63:0] pack(input logic [15:0] m [16], input int r);
        return {m[r*4+3], m[r*4+2], m[r*4+1], m[r*4+0]};
    endfunction

    task automatic compute_y();
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic signed [63:0] acc;
                acc = 0;
                for (int k = 0; k < 4; k++) begin
                    logic signed [15:0] as, bs;
                    logic signed [31:0] p;
                    as = ma[i*4+k];
                    bs = mb[k*4+j];
                    p = as * bs;
                    acc = acc + 64'(p >>> FB);
                end
                my[i*4+j] = acc[15:0];
            end
        end
    endtask

    task automatic load_b();
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            b_we  = 1'b1;
            b_row = pack(mb, r);
        end
        @(negedge clk);
        b_we  = 1'b0;
        b_row = '0;
    endtask

    // drives one burst and checks its rows; strays inject ignored requests
    task automatic run_burst(input bit stray_start, input bit stray_we, input string tag);
        bit low_early = 1;
        bit low_late  = 1;
        @(negedge clk);
        start = 1'b1;
        a_row = pack(ma, 0);
        for (int idx = 1; idx <= 16; idx++) begin
            @(negedge clk);
            start = 1'b0;
            b_we  = 1'b0;
            a_row = (idx <= 3) ? pack(ma, idx) : 64'h0;
            if (stray_start && (idx == 2 || idx == 6)) start = 1'b1;
            if (stray_we && (idx == 2 || (idx >= 5 && idx <= 8))) begin
                b_we  = 1'b1;
                b_row = 64'h1111_2222_3333_4444;
            end
            if (idx <= 7 && y_valid) low_early = 0;
            if (idx >= 12 && y_valid) low_late = 0;
            if (idx >= 8 && idx <= 11) begin
                chk(y_valid === 1'b1, {tag, " R5 valid row"}, 64'(y_valid), 64'h1);
                chk(y_row === pack(my, idx - 8), {tag, " R4 row value"}, y_row, pack(my, idx - 8));
            end
        end
        start = 1'b0;
        b_we  = 1'b0;
        chk(low_early, {tag, " R5 no early valid"}, 64'(low_early), 64'h1);
        chk(low_late, {tag, " R6 exactly four rows"}, 64'(low_late), 64'h1);
    endtask

    task automatic gen(input logic [63:0] cs);
        for (int n = 0; n < 16; n++) begin
            ma[n] = cs[63:48] + cs[47:32] * 16'(n);
            mb[n] = cs[31:16] + cs[15:0] * 16'((n * 5) % 16);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(y_valid === 1'b0, "R1 valid low after reset", 64'(y_valid), 64'h0);
        chk(y_row === '0, "R1 outputs zero after reset", y_row, 64'h0);

        // R2 R3 R4 R5: table-driven bursts
        for (int t = 0; t < 5; t++) begin
            gen(CASES[t]);
            compute_y();
            load_b();
            run_burst(0, 0, "table R2 R3");
        end

        // R4: identity B returns A
        for (int n = 0; n < 16; n++) begin
            mb[n] = (n % 5 == 0) ? 16'h0400 : 16'h0000;
            ma[n] = 16'(n * 16'h0155) ^ 16'h8A3C;
        end
        compute_y();
        for (int n = 0; n < 16; n++) chk(my[n] === ma[n], "R4 identity model", 64'(my[n]), 64'(ma[n]));
        load_b();
        run_burst(0, 0, "identity R4");

        // R9: rounding of the shift toward minus infinity
        for (int n = 0; n < 16; n++) begin ma[n] = 16'h0; mb[n] = 16'h0; end
        ma[0] = 16'hFFFF; ma[4] = 16'h0001; mb[0] = 16'h0001;
        compute_y();
        chk(my[0] === 16'hFFFF && my[4] === 16'h0000, "R9 model floor", {my[0], my[4]}, 64'hFFFF_0000);
        load_b();
        run_burst(0, 0, "floor R9");

        // R4: full-scale operands wrap on truncation
        for (int n = 0; n < 16; n++) begin ma[n] = 16'h7FFF; mb[n] = 16'h7FFF; end
        compute_y();
        load_b();
        run_burst(0, 0, "wrap R4");

        // R6 R7: stray start and write requests during RUN and DRAIN
        gen(CASES[1]);
        compute_y();
        load_b();
        run_burst(1, 1, "stray R6 R7");
        for (int n = 0; n < 16; n++) ma[n] = 16'(n * 16'h0210) - 16'h0800;
        compute_y();
        run_burst(0, 0, "B retained R7");

        // R8: simultaneous write and start in IDLE
        begin
            bit quiet = 1;
            gen(CASES[2]);
            compute_y();
            @(negedge clk);
            b_we = 1'b1; start = 1'b1; b_row = pack(mb, 0); a_row = 64'hDEAD_BEEF_0BAD_F00D;
            for (int r = 1; r < 4; r++) begin
                @(negedge clk);
                start = 1'b0; a_row = '0; b_row = pack(mb, r);
                if (y_valid) quiet = 0;
            end
            @(negedge clk);
            b_we = 1'b0; b_row = '0;
            for (int w = 0; w < 12; w++) begin
                @(negedge clk);
                if (y_valid) quiet = 0;
            end
            chk(quiet, "R8 start lost to load", 64'(quiet), 64'h1);
            run_burst(0, 0, "after R8 load");
        end

        // R10: reset during a burst
        begin
            bit quiet = 1;
            @(negedge clk);
            start = 1'b1; a_row = pack(ma, 0);
            for (int idx = 1; idx <= 5; idx++) begin
                @(negedge clk);
                start = 1'b0;
                a_row = (idx <= 3) ? pack(ma, idx) : 64'h0;
            end
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            for (int w = 0; w < 14; w++) begin
                @(negedge clk);
                if (y_valid) quiet = 0;
            end
            chk(quiet, "R10 burst cancelled", 64'(quiet), 64'h1);
            chk(y_row === '0, "R10 R1 outputs cleared", y_row, 64'h0);
            for (int n = 0; n < 16; n++) mb[n] = 16'h0;
            compute_y();
            run_burst(0, 0, "R10 B cleared");
        end

        done = 1;
        report();
    end

endmodule